// File: doc/BRIEF.md
# Strap-configured parallel host to AHB-Lite bridge

This block lets an external processor with an asynchronous parallel bus read and write the on-chip AHB-Lite fabric. Each host access that needs the fabric is turned into one single, non-locked AHB word transfer. A ready/wait output holds the host until the data phase of that transfer has completed. The host strobes and chip select pass through two-flop synchronizers. Address and write data are sampled directly, so the host must hold them stable while its strobe is asserted.

Three options come from strap pins: host data width (16 or 32 bits), ready polarity, and strobe style (one write-enable line whose level gives the direction, or separate read and write strobes). The straps are captured in the first clock after power-on reset is released. Internal software can later rewrite them through a single APB register, which also holds a sticky bus-error flag that drives an interrupt. A new configuration written over APB takes effect only once no host access is in progress.

In 16-bit mode one AHB word takes two host accesses, and host address bit 1 picks the half. A write reaches the fabric when the high half arrives. A read fetches the word on the low-half access and returns the held upper half on the high-half access.

Top module: `hostbus_ahb_bridge`

## Requirements
- R1: In 32-bit mode every host access produces exactly one AHB transfer with HTRANS=NONSEQ (2'b10) and HSIZE=3'b010. HADDR is the host byte address with bits [1:0] cleared, HWRITE follows the access direction, HWDATA is the host write word, and HADDR stays stable while HREADY is low.
- R2: HBURST is always 3'b000, HPROT is always 4'b0001 and HMASTLOCK is always 0.
- R3: The APB register bits [2:0] = {strobe style, ready polarity, width} are loaded from strap_split, strap_rdy_low and strap_wide in the first clock after rst_n rises.
- R4: Width bit 0 selects a 16-bit host bus (data on bits [15:0]). A write with host_addr[1]=0 stores the low half and makes no AHB transfer. A write with host_addr[1]=1 makes one AHB write of {high half, stored low half}.
- R5: In 16-bit mode a read with host_addr[1]=0 makes one AHB read and returns bits [15:0]. A read with host_addr[1]=1 makes no AHB transfer and returns bits [31:16] of the word fetched earlier, with upper output bits zero.
- R6: host_rdy is at its not-ready level from the start of the AHB address phase until the data phase completes, and at its ready level otherwise. When polarity bit 1 is 0, ready is 1. When it is 1, ready is 0.
- R7: With strobe-style bit 2 = 1, an access needs chip select low plus host_rd_n or host_wr_n low, and chip select alone starts nothing. With bit 2 = 0, chip select low starts an access, host_wr_n low means write and high means read, and host_rd_n is ignored.
- R8: An AHB ERROR response sets a sticky flag that drives irq_buserr. An APB write with bit 8 = 1 clears it. Reset clears it.
- R9: An APB read returns the configuration in bits [2:0] and the error flag in bit 8, with all other bits zero. An APB write updates bits [2:0] of the configuration.
- R10: A configuration written over APB while a host access is in progress is applied only after the host has released its strobes, and read-back shows the old value until then.
- R11: Read data stays on host_rdata after completion until the next access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| strap_wide | input | 1 | Width strap, 1 = 32-bit host bus |
| strap_rdy_low | input | 1 | Ready polarity strap, 1 = active-low ready |
| strap_split | input | 1 | Strobe style strap, 1 = separate read/write strobes |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_wr_n | input | 1 | Host write strobe or direction line |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data |
| host_rdy | output | 1 | Host ready/wait |
| haddr | output | 32 | AHB address |
| htrans | output | 2 | AHB transfer type |
| hwrite | output | 1 | AHB direction |
| hsize | output | 3 | AHB size |
| hburst | output | 3 | AHB burst type |
| hprot | output | 4 | AHB protection |
| hmastlock | output | 1 | AHB lock |
| hwdata | output | 32 | AHB write data |
| hrdata | input | 32 | AHB read data |
| hready | input | 1 | AHB ready |
| hresp | input | 1 | AHB response, 1 = ERROR |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable |
| pwrite | input | 1 | APB direction |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| irq_buserr | output | 1 | Sticky bus-error interrupt |

## Verification
A host strobe driven at a falling edge is seen after two synchronizer edges. The AHB address phase starts at the third rising edge, so the bench samples the not-ready level of host_rdy at the fourth falling edge, while the slave model is still inserting wait states. A transfer that needs no fabric access must show the ready level and an unchanged transfer count at that same point. Completion is found by polling host_rdy at falling edges, and read data is taken in that same half cycle. The fixed AHB control fields and the interrupt line are compared against the bench model at every falling edge. The model's interrupt flag changes at the rising edge where the error data phase ends or the APB clear lands.

// File: rtl/hostbus_ahb_bridge.sv
module hostbus_ahb_bridge #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_wide,
  input  logic              strap_rdy_low,
  input  logic              strap_split,
  input  logic              host_cs_n,
  input  logic              host_rd_n,
  input  logic              host_wr_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [31:0]       host_wdata,
  output logic [31:0]       host_rdata,
  output logic              host_rdy,
  output logic [31:0]       haddr,
  output logic [1:0]        htrans,
  output logic              hwrite,
  output logic [2:0]        hsize,
  output logic [2:0]        hburst,
  output logic [3:0]        hprot,
  output logic              hmastlock,
  output logic [31:0]       hwdata,
  input  logic [31:0]       hrdata,
  input  logic              hready,
  input  logic              hresp,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [31:0]       pwdata,
  output logic [31:0]       prdata,
  output logic              irq_buserr
);
  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_DONE} state_t;

  state_t            st;
  logic [1:0]        cs_s, rd_s, wr_s;
  logic              boot, err, cfg_pend;
  logic [2:0]        cfg_q, cfg_nx;
  logic [ADDR_W-1:0] cap_addr;
  logic              cap_write;
  logic [31:0]       wbuf, rbuf;
  logic              active, is_wr, need_ahb, apb_wr, busy;
  logic              unused_bits;

  assign active   = !cs_s[1] && (!cfg_q[2] || !rd_s[1] || !wr_s[1]);
  assign is_wr    = !wr_s[1];
  assign need_ahb = cfg_q[0] || (is_wr ? host_addr[1] : !host_addr[1]);
  assign apb_wr   = psel && penable && pwrite;
  assign busy     = (st == S_ADDR) || (st == S_DATA);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_s <= 2'b11; rd_s <= 2'b11; wr_s <= 2'b11;
    end else begin
      cs_s <= {cs_s[0], host_cs_n};
      rd_s <= {rd_s[0], host_rd_n};
      wr_s <= {wr_s[0], host_wr_n};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      boot <= 1'b1; cfg_q <= 3'b000; cfg_nx <= 3'b000; cfg_pend <= 1'b0;
    end else begin
      boot <= 1'b0;
      if (apb_wr) begin
        cfg_nx   <= pwdata[2:0];
        cfg_pend <= 1'b1;
      end
      if (boot)
        cfg_q <= {strap_split, strap_rdy_low, strap_wide};
      else if (cfg_pend && st == S_IDLE && !active && !apb_wr) begin
        cfg_q    <= cfg_nx;
        cfg_pend <= 1'b0;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; cap_addr <= '0; cap_write <= 1'b0;
      wbuf <= '0; rbuf <= '0; err <= 1'b0;
    end else begin
      if (apb_wr && pwdata[8]) err <= 1'b0;
      unique case (st)
        S_IDLE: if (active) begin
          cap_addr  <= host_addr;
          cap_write <= is_wr;
          if (is_wr) begin
            if (cfg_q[0])          wbuf          <= host_wdata;
            else if (host_addr[1]) wbuf[31:16]   <= host_wdata[15:0];
            else                   wbuf[15:0]    <= host_wdata[15:0];
          end
          st <= need_ahb ? S_ADDR : S_DONE;
        end
        S_ADDR: if (hready) st <= S_DATA;
        S_DATA: if (hready) begin
          if (hresp) err <= 1'b1;
          if (!cap_write) rbuf <= hrdata;
          st <= S_DONE;
        end
        S_DONE: if (!active) st <= S_IDLE;
      endcase
    end

  assign haddr      = {{(32-ADDR_W){1'b0}}, cap_addr[ADDR_W-1:2], 2'b00};
  assign htrans     = (st == S_ADDR) ? 2'b10 : 2'b00;
  assign hwrite     = cap_write;
  assign hsize      = 3'b010;
  assign hburst     = 3'b000;
  assign hprot      = 4'b0001;
  assign hmastlock  = 1'b0;
  assign hwdata     = wbuf;
  assign host_rdy   = busy ? cfg_q[1] : !cfg_q[1];
  assign host_rdata = cfg_q[0] ? rbuf : {16'h0, cap_addr[1] ? rbuf[31:16] : rbuf[15:0]};
  assign prdata     = {23'h0, err, 5'h0, cfg_q};
  assign irq_buserr = err;
  assign unused_bits = ^{pwdata[31:9], pwdata[7:3], host_addr[0]};
endmodule

// File: rtl/hostbus_ahb_bridge_chk.sv
module hostbus_ahb_bridge_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  htrans,
  input logic [31:0] haddr,
  input logic        hready,
  input logic        hresp,
  input logic        host_rdy,
  input logic        cfg_rdy_low,
  input logic        irq_buserr,
  input logic        psel,
  input logic        penable,
  input logic        pwrite,
  input logic        pwdata8
);
  logic dph;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) dph <= 1'b0;
    else if (htrans == 2'b10 && hready) dph <= 1'b1;
    else if (hready) dph <= 1'b0;

  AST_SINGLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    htrans == 2'b00 || htrans == 2'b10);                                       // R1
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    htrans == 2'b10 && !hready |=> htrans == 2'b10 && $stable(haddr));         // R1
  AST_WAIT_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    htrans == 2'b10 |-> host_rdy == cfg_rdy_low);                             // R6
  AST_WAIT_IN_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    dph && !hready |-> host_rdy == cfg_rdy_low);                              // R6
  AST_ERR_TO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    dph && hready && hresp |=> irq_buserr);                                   // R8
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_buserr && !(psel && penable && pwrite && pwdata8) |=> irq_buserr);    // R8
endmodule

bind hostbus_ahb_bridge hostbus_ahb_bridge_chk u_chk (
  .clk(clk), .rst_n(rst_n), .htrans(htrans), .haddr(haddr), .hready(hready),
  .hresp(hresp), .host_rdy(host_rdy), .cfg_rdy_low(cfg_q[1]),
  .irq_buserr(irq_buserr), .psel(psel), .penable(penable), .pwrite(pwrite),
  .pwdata8(pwdata[8])
);

// File: tb/tb_hostbus_ahb_bridge.sv
module tb_hostbus_ahb_bridge;
  logic clk = 0, rst_n = 0;
  logic s_wide = 1, s_low = 0, s_split = 1;
  logic cs_n = 1, rd_n = 1, wr_n = 1;
  logic [15:0] h_addr = 0;
  logic [31:0] h_wdata = 0, h_rdata;
  logic h_rdy;
  logic [31:0] haddr, hwdata, hrdata, prdata, pwdata = 0;
  logic [1:0] htrans;
  logic hwrite, hmastlock, irq, psel = 0, penable = 0, pwrite = 0;
  logic [2:0] hsize, hburst;
  logic [3:0] hprot;
  logic hready, hresp;

  int tests = 0, fails = 0, xfers = 0, slave_waits = 0;
  bit slave_err = 0, exp_irq = 0, run = 0, split = 1, low = 0;
  logic [31:0] last_addr = 0;
  bit last_write = 0;

  logic [31:0] mem [0:255];
  logic dph = 0, w_q = 0, err_cur = 0;
  logic [31:0] a_q = 0;
  int cnt = 0;

  always #4 clk = ~clk;

  hostbus_ahb_bridge dut (
    .clk(clk), .rst_n(rst_n), .strap_wide(s_wide), .strap_rdy_low(s_low),
    .strap_split(s_split), .host_cs_n(cs_n), .host_rd_n(rd_n), .host_wr_n(wr_n),
    .host_addr(h_addr), .host_wdata(h_wdata), .host_rdata(h_rdata), .host_rdy(h_rdy),
    .haddr(haddr), .htrans(htrans), .hwrite(hwrite), .hsize(hsize), .hburst(hburst),
    .hprot(hprot), .hmastlock(hmastlock), .hwdata(hwdata), .hrdata(hrdata),
    .hready(hready), .hresp(hresp), .psel(psel), .penable(penable), .pwrite(pwrite),
    .pwdata(pwdata), .prdata(prdata), .irq_buserr(irq)
  );

  assign hready = !dph || cnt == 0;
  assign hresp  = dph && err_cur && cnt <= 1;
  assign hrdata = (dph && !w_q) ? mem[a_q[9:2]] : 32'h0;

  always @(posedge clk) begin
    if (!rst_n) begin
      dph <= 0; cnt <= 0;
    end else begin
      if (dph && hready) begin
        if (err_cur) exp_irq = 1;
        else if (w_q) mem[a_q[9:2]] = hwdata;
        dph <= 0;
      end else if (dph) cnt <= cnt - 1;
      if ((!dph || hready) && htrans == 2'b10) begin
        dph <= 1; a_q <= haddr; w_q <= hwrite; err_cur <= slave_err;
        cnt <= (slave_err && slave_waits < 1) ? 1 : slave_waits;
        xfers++; last_addr = haddr; last_write = hwrite;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (run && rst_n) begin
    chk(hburst == 3'b000 && hprot == 4'b0001 && !hmastlock, "R2 fixed ctrl",
        {hburst, hprot, hmastlock}, {3'b000, 4'b0001, 1'b0});
    chk(hsize == 3'b010, "R1 hsize", {29'h0, hsize}, 32'h2);
    chk(irq == exp_irq, "R8 irq model", {31'h0, irq}, {31'h0, exp_irq});
  end

  task automatic do_reset(input logic w, input logic l, input logic s);
    rst_n = 0; s_wide = w; s_low = l; s_split = s; exp_irq = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    split = s; low = l;
  endtask

  task automatic apb_write(input logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 1; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(posedge clk); #1 if (d[8]) exp_irq = 0;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(output logic [31:0] d);
    @(negedge clk); psel = 1; pwrite = 0; penable = 0;
    @(negedge clk); penable = 1; d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic host_start(input bit w, input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    h_addr = a; h_wdata = d; cs_n = 0;
    if (split) begin if (w) wr_n = 0; else rd_n = 0; end
    else wr_n = !w;
  endtask

  task automatic host_finish(output logic [31:0] rd);
    int n;
    n = 0;
    while (h_rdy != !low && n < 1000) begin @(negedge clk); n++; end
    chk(n < 1000, "R6 ready returns", {31'h0, h_rdy}, {31'h0, !low});
    rd = h_rdata;
    @(negedge clk); cs_n = 1; rd_n = 1; wr_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic access(input bit w, input logic [15:0] a, input logic [31:0] d,
                        input bit exp_busy, input string req, output logic [31:0] rd);
    int x0;
    x0 = xfers;
    host_start(w, a, d);
    repeat (4) @(negedge clk);
    chk(h_rdy == (exp_busy ? low : !low), req, {31'h0, h_rdy}, {31'h0, exp_busy ? low : !low});
    host_finish(rd);
    chk(xfers - x0 == (exp_busy ? 1 : 0), req, xfers - x0, exp_busy ? 1 : 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] r;
    int x0;
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    do_reset(1, 0, 1);
    run = 1;
    chk(h_rdy == 1'b1, "R6 idle ready high", {31'h0, h_rdy}, 32'h1);
    chk(htrans == 2'b00, "R1 idle htrans", {30'h0, htrans}, 32'h0);
    apb_read(r);
    chk(r == 32'h5, "R3 strap capture", r, 32'h5);

    slave_waits = 3;
    access(1, 16'h0124, 32'hCAFE1234, 1, "R1 write32", r);
    chk(last_addr == 32'h124 && last_write, "R1 write addr", last_addr, 32'h124);
    chk(mem[8'h49] == 32'hCAFE1234, "R1 write data", mem[8'h49], 32'hCAFE1234);
    access(0, 16'h0126, 0, 1, "R1 read32", r);
    chk(last_addr == 32'h124 && !last_write, "R1 read addr aligned", last_addr, 32'h124);
    chk(r == 32'hCAFE1234, "R11 read data", r, 32'hCAFE1234);
    repeat (5) @(negedge clk);
    chk(h_rdata == 32'hCAFE1234, "R11 data held", h_rdata, 32'hCAFE1234);

    x0 = xfers;
    @(negedge clk); cs_n = 0;
    repeat (8) @(negedge clk);
    chk(xfers == x0 && h_rdy == 1'b1, "R7 split needs strobe", xfers - x0, 0);
    cs_n = 1; repeat (4) @(negedge clk);

    slave_err = 1;
    access(1, 16'h0040, 32'h11112222, 1, "R8 error xfer", r);
    slave_err = 0;
    chk(irq == 1'b1, "R8 irq set", {31'h0, irq}, 32'h1);
    apb_read(r);
    chk(r == 32'h105, "R9 status readback", r, 32'h105);
    apb_write(32'h005);
    chk(irq == 1'b1, "R8 sticky without bit8", {31'h0, irq}, 32'h1);
    apb_write(32'h105);
    chk(irq == 1'b0, "R8 clear", {31'h0, irq}, 32'h0);

    slave_waits = 12;
    host_start(1, 16'h0080, 32'h0BADF00D);
    repeat (4) @(negedge clk);
    apb_write(32'h007);
    apb_read(r);
    chk(r == 32'h005, "R10 deferred readback", r, 32'h005);
    chk(h_rdy == 1'b0, "R10 polarity unchanged busy", {31'h0, h_rdy}, 32'h0);
    host_finish(r);
    low = 1;
    apb_read(r);
    chk(r == 32'h007, "R10 applied after release", r, 32'h007);
    chk(h_rdy == 1'b0, "R6 active-low idle", {31'h0, h_rdy}, 32'h0);

    slave_waits = 3;
    do_reset(0, 1, 0);
    apb_read(r);
    chk(r == 32'h2, "R3 second strap set", r, 32'h2);
    chk(h_rdy == 1'b0, "R6 low polarity ready", {31'h0, h_rdy}, 32'h0);
    access(1, 16'h0200, 32'hFFFFBEEF, 0, "R4 low half no xfer", r);
    access(1, 16'h0202, 32'h00001234, 1, "R4 high half commit", r);
    chk(mem[8'h80] == 32'h1234BEEF && last_write, "R4 word committed", mem[8'h80], 32'h1234BEEF);
    rd_n = 0;
    access(0, 16'h0200, 0, 1, "R7 combined read", r);
    rd_n = 1;
    chk(!last_write && r == 32'h0000BEEF, "R5 low half read", r, 32'h0000BEEF);
    mem[8'h80] = 32'h55556666;
    access(0, 16'h0202, 0, 0, "R5 high half no xfer", r);
    chk(r == 32'h00001234, "R5 high half held", r, 32'h00001234);

    run = 0;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule